// File: doc/BRIEF.md
# Program Stack Sequencer

This block keeps the return stack of a small 8-bit controller. A subroutine call or an interrupt entry pushes the 13-bit program counter and the 3-bit flags into a byte-wide data RAM as two bytes. A return or a return-from-interrupt pops them back. The block owns the 8-bit program stack pointer. It drives the global interrupt-enable bit: interrupt entry clears the bit, and return-from-interrupt sets it again.

A command is taken only while the block is idle. Every operation then runs for three cycles: two cycles that each make one RAM access, then one completion cycle in which `done` is high. The RAM port has a read path with no clock delay: `ram_rdata` must show the byte at `ram_addr` in the same cycle. Writes take effect on the clock edge.

Byte layout: the low byte holds PC[7:0]. The high byte holds PC[12:8] in bits 4:0 and the flags in bits 7:5. A save writes the low byte first, at the pointer. A restore reads the high byte first, at the pointer minus one.

Top module: `pstack_seq`

## Requirements
- R1: After reset the pointer `psp` is 0x00, `gie` is 0, and `busy` and `done` are 0. No RAM access (`ram_we`, `ram_re`) happens while the block is idle.
- R2: On a save (call or interrupt), the first busy cycle writes PC[7:0] at address `psp`. The second busy cycle writes {flags, PC[12:8]} at `psp`+1. When the operation ends, `psp` has grown by 2.
- R3: On a return-from-interrupt, the first busy cycle reads the high byte at `psp`-1 and the second reads the low byte at `psp`-2. In the completion cycle `pc_out` is {high[4:0], low} and `flags_out` is high[7:5], and `psp` has dropped by 2.
- R4: On a plain return, `pc_out` is restored from the stack as in R3. `flags_out` takes the `flags_in` value present when the command was taken. `psp` drops by 2 and `gie` does not change.
- R5: An interrupt command clears `gie` from the first busy cycle on. A call leaves `gie` unchanged.
- R6: A return-from-interrupt raises `gie` only in the completion cycle, never during the two access cycles.
- R7: A command taken at a clock edge makes `busy` high for exactly the next three cycles. `done` is high only in the third of those cycles, for exactly one cycle.
- R8: Commands presented while `busy` is high are ignored. They change neither `psp` nor `gie`, and they start no further operation.
- R9: The pointer and the RAM addresses wrap modulo 256: 0xFF+1 gives 0x00 and 0x00-1 gives 0xFF.
- R10: When several commands are presented together, the priority is interrupt, then call, then return-from-interrupt, then return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_call | input | 1 | Subroutine call request |
| cmd_int | input | 1 | Interrupt entry request |
| cmd_ret | input | 1 | Subroutine return request |
| cmd_reti | input | 1 | Return-from-interrupt request |
| pc_in | input | 13 | Current program counter |
| flags_in | input | 3 | Current flags |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 13 | Restored program counter |
| flags_out | output | 3 | Restored (or kept) flags |
| gie | output | 1 | Global interrupt enable |
| psp | output | 8 | Program stack pointer |
| ram_addr | output | 8 | RAM byte address |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid in the same cycle |

## Verification
A pointer stepped the wrong way or at the wrong time shows up as a wrong `ram_addr` within a single access cycle, and as a wrong `psp` in the completion cycle. A swapped byte order or a misplaced flag field shows up in the RAM image just after a save, or in `pc_out`/`flags_out` in the completion cycle of the following restore. A state machine that leaves its sequence or accepts a command while busy shows up as an extra `busy` cycle, a second `done`, or a pointer moved by four, all within the next four cycles. A misrouted interrupt enable shows up as `gie` changing in the wrong busy cycle.

// File: rtl/pstack_pkg.sv
package pstack_pkg;

  localparam int PC_W   = 13;
  localparam int FL_W   = 3;
  localparam int BYTE_W = 8;
  localparam int PCH_W  = PC_W - BYTE_W;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC1, ST_ACC2, ST_FIN} seq_st_t;
  typedef enum logic [1:0] {OP_CALL, OP_INT, OP_RET, OP_RETI} seq_op_t;

  function automatic logic [BYTE_W-1:0] lo_byte(input logic [PC_W-1:0] pc);
    return pc[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] hi_byte(input logic [PC_W-1:0] pc,
                                                input logic [FL_W-1:0] fl);
    return {fl, pc[PC_W-1:BYTE_W]};
  endfunction

  function automatic logic [PC_W-1:0] pc_join(input logic [BYTE_W-1:0] hi,
                                              input logic [BYTE_W-1:0] lo);
    return {hi[PCH_W-1:0], lo};
  endfunction

  function automatic logic [FL_W-1:0] fl_of(input logic [BYTE_W-1:0] hi);
    return hi[BYTE_W-1:PCH_W];
  endfunction

  function automatic logic is_save(input seq_op_t op);
    return (op == OP_CALL) || (op == OP_INT);
  endfunction

endpackage

// File: rtl/pstack_fsm.sv
module pstack_fsm
  import pstack_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmd_call,
  input  logic    cmd_int,
  input  logic    cmd_ret,
  input  logic    cmd_reti,
  output seq_op_t op,
  output logic    accept,
  output logic    accept_int,
  output logic    in_acc1,
  output logic    in_acc2,
  output logic    busy,
  output logic    done
);

  seq_st_t st;
  seq_op_t next_op;
  logic    req_any;

  always_comb begin
    req_any = cmd_int | cmd_call | cmd_reti | cmd_ret;
    if (cmd_int)       next_op = OP_INT;
    else if (cmd_call) next_op = OP_CALL;
    else if (cmd_reti) next_op = OP_RETI;
    else               next_op = OP_RET;
  end

  assign accept     = (st == ST_IDLE) && req_any;
  assign accept_int = accept && (next_op == OP_INT);
  assign in_acc1    = (st == ST_ACC1);
  assign in_acc2    = (st == ST_ACC2);
  assign busy       = (st != ST_IDLE);
  assign done       = (st == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      op <= OP_CALL;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          st <= ST_ACC1;
          op <= next_op;
        end
        ST_ACC1: st <= ST_ACC2;
        ST_ACC2: st <= ST_FIN;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pstack_ptr.sv
module pstack_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  output logic [PTR_W-1:0] ptr
);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p,
                                                input logic up, input logic dn);
    if (up)      return p + 1'b1;
    else if (dn) return p - 1'b1;
    else         return p;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_next(ptr, step_up, step_dn);
  end

endmodule

// File: rtl/pstack_dp.sv
module pstack_dp
  import pstack_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_op_t           op,
  input  logic              accept,
  input  logic              accept_int,
  input  logic              in_acc1,
  input  logic              in_acc2,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [FL_W-1:0]   flags_in,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic [PTR_W-1:0]  ram_addr,
  output logic              ram_we,
  output logic              ram_re,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              ptr_up,
  output logic              ptr_dn,
  output logic [PC_W-1:0]   pc_out,
  output logic [FL_W-1:0]   flags_out,
  output logic              gie
);

  function automatic logic [PTR_W-1:0] below(input logic [PTR_W-1:0] p);
    return p - 1'b1;
  endfunction

  logic [PC_W-1:0]   pc_q;
  logic [FL_W-1:0]   fl_q;
  logic [BYTE_W-1:0] hi_q;
  logic              saving;
  logic              acc;

  assign saving    = is_save(op);
  assign acc       = in_acc1 | in_acc2;
  assign ram_we    = acc & saving;
  assign ram_re    = acc & ~saving;
  assign ram_addr  = saving ? ptr : below(ptr);
  assign ram_wdata = in_acc1 ? lo_byte(pc_q) : hi_byte(pc_q, fl_q);
  assign ptr_up    = ram_we;
  assign ptr_dn    = ram_re;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q      <= '0;
      fl_q      <= '0;
      hi_q      <= '0;
      pc_out    <= '0;
      flags_out <= '0;
      gie       <= 1'b0;
    end else begin
      if (accept) begin
        pc_q <= pc_in;
        fl_q <= flags_in;
      end
      if (accept_int) gie <= 1'b0;
      if (ram_re && in_acc1) hi_q <= ram_rdata;
      if (ram_re && in_acc2) begin
        pc_out    <= pc_join(hi_q, ram_rdata);
        flags_out <= (op == OP_RETI) ? fl_of(hi_q) : fl_q;
        if (op == OP_RETI) gie <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pstack_seq.sv
module pstack_seq
  import pstack_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_call,
  input  logic              cmd_int,
  input  logic              cmd_ret,
  input  logic              cmd_reti,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [FL_W-1:0]   flags_in,
  output logic              busy,
  output logic              done,
  output logic [PC_W-1:0]   pc_out,
  output logic [FL_W-1:0]   flags_out,
  output logic              gie,
  output logic [PTR_W-1:0]  psp,
  output logic [PTR_W-1:0]  ram_addr,
  output logic              ram_we,
  output logic              ram_re,
  output logic [BYTE_W-1:0] ram_wdata,
  input  logic [BYTE_W-1:0] ram_rdata
);

  seq_op_t op;
  logic    accept;
  logic    accept_int;
  logic    in_acc1;
  logic    in_acc2;
  logic    ptr_up;
  logic    ptr_dn;

  pstack_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_call(cmd_call), .cmd_int(cmd_int), .cmd_ret(cmd_ret), .cmd_reti(cmd_reti),
    .op(op), .accept(accept), .accept_int(accept_int),
    .in_acc1(in_acc1), .in_acc2(in_acc2), .busy(busy), .done(done)
  );

  pstack_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .step_up(ptr_up), .step_dn(ptr_dn), .ptr(psp)
  );

  pstack_dp #(.PTR_W(PTR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .op(op), .accept(accept), .accept_int(accept_int),
    .in_acc1(in_acc1), .in_acc2(in_acc2), .pc_in(pc_in), .flags_in(flags_in),
    .ptr(psp), .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_re(ram_re), .ram_wdata(ram_wdata), .ptr_up(ptr_up), .ptr_dn(ptr_dn),
    .pc_out(pc_out), .flags_out(flags_out), .gie(gie)
  );

endmodule

// File: rtl/pstack_chk.sv
module pstack_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             gie,
  input logic             ram_we,
  input logic             ram_re,
  input logic [PTR_W-1:0] ram_addr,
  input logic [PTR_W-1:0] psp,
  input logic             accept_int
);

  // R1
  idle_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ram_we && !ram_re));

  // R2
  wr_at_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr == psp));

  // R2
  wr_step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (psp == $past(psp) + 1'b1));

  // R3
  rd_below_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |-> (ram_addr == psp - 1'b1));

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we && !ram_re) |=> $stable(psp));

  // R5
  int_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_int |=> !gie);

  // R6
  gie_rise_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gie) |-> done);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R7
  done_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

endmodule

bind pstack_seq pstack_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .gie(gie),
  .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr), .psp(psp),
  .accept_int(accept_int)
);

// File: tb/pstack_seq_tb.sv
`timescale 1ns/1ps
module pstack_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cmd = 4'b0;   // {int, call, reti, ret}
  logic [12:0] pc_in = '0;
  logic [2:0]  flags_in = '0;
  logic        busy, done, gie, ram_we, ram_re;
  logic [12:0] pc_out;
  logic [2:0]  flags_out;
  logic [7:0]  psp, ram_addr, ram_wdata, ram_rdata;
  logic [7:0]  mem [256];

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pstack_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_call(cmd[2]), .cmd_int(cmd[3]), .cmd_ret(cmd[0]), .cmd_reti(cmd[1]),
    .pc_in(pc_in), .flags_in(flags_in), .busy(busy), .done(done),
    .pc_out(pc_out), .flags_out(flags_out), .gie(gie), .psp(psp),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

  localparam logic [3:0] C_INT = 4'b1000, C_CALL = 4'b0100,
                         C_RETI = 4'b0010, C_RET = 4'b0001;

  // samples of one operation
  logic b1, b2, b3, b4, d1, d2, d3, d4, g1, g2, g3, we1, re1, we2;
  logic [7:0] a1, a2, p3;
  logic [12:0] pc3;
  logic [2:0] fl3;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] c, input logic [12:0] pc, input logic [2:0] fl,
                        input logic [3:0] n_acc1, input logic [3:0] n_fin);
    pc_in = pc; flags_in = fl;
    @(negedge clk) cmd = c;
    @(negedge clk) cmd = n_acc1;
    b1 = busy; d1 = done; g1 = gie; a1 = ram_addr; we1 = ram_we; re1 = ram_re;
    @(negedge clk) cmd = 4'b0;
    b2 = busy; d2 = done; g2 = gie; a2 = ram_addr; we2 = ram_we;
    @(negedge clk) cmd = n_fin;
    b3 = busy; d3 = done; g3 = gie; p3 = psp; pc3 = pc_out; fl3 = flags_out;
    @(negedge clk) cmd = 4'b0;
    b4 = busy; d4 = done;
  endtask

  task automatic t_reset();
    chk(psp == 8'h00, "R1 psp", psp, 0);
    chk(!gie && !busy && !done, "R1 gie/busy/done", {gie, busy, done}, 0);
    chk(!ram_we && !ram_re, "R1 ram idle", {ram_we, ram_re}, 0);
  endtask

  task automatic t_call();
    run_op(C_CALL, 13'h1ABC, 3'd5, 4'b0, 4'b0);
    chk(we1 && we2 && !re1, "R2 writes", {we1, we2, re1}, 3'b110);
    chk(a1 == 8'h00 && a2 == 8'h01, "R2 addrs", {a1, a2}, 16'h0001);
    chk(mem[0] == 8'hBC, "R2 low byte", mem[0], 8'hBC);
    chk(mem[1] == 8'hBA, "R2 high byte", mem[1], 8'hBA);
    chk(p3 == 8'h02, "R2 psp+2", p3, 2);
    chk(!g1 && !g3, "R5 call keeps gie", {g1, g3}, 0);
    chk(b1 && b2 && b3 && !b4, "R7 busy window", {b1, b2, b3, b4}, 4'b1110);
    chk(!d1 && !d2 && d3 && !d4, "R7 done pulse", {d1, d2, d3, d4}, 4'b0010);
  endtask

  task automatic t_reti();
    run_op(C_RETI, 13'h0000, 3'd0, 4'b0, 4'b0);
    chk(re1 && !we1, "R3 reads", {re1, we1}, 2'b10);
    chk(a1 == 8'h01 && a2 == 8'h00, "R3 addrs", {a1, a2}, 16'h0100);
    chk(pc3 == 13'h1ABC, "R3 pc", pc3, 13'h1ABC);
    chk(fl3 == 3'd5, "R3 flags", fl3, 5);
    chk(p3 == 8'h00, "R3 psp-2", p3, 0);
    chk(!g1 && !g2 && g3, "R6 gie timing", {g1, g2, g3}, 3'b001);
  endtask

  task automatic t_int();
    run_op(C_INT, 13'h0F0F, 3'd2, 4'b0, 4'b0);
    chk(!g1 && !g3, "R5 int clears gie", {g1, g3}, 0);
    chk(mem[0] == 8'h0F && mem[1] == 8'h4F, "R2 int bytes", {mem[0], mem[1]}, 16'h0F4F);
    chk(p3 == 8'h02, "R2 int psp", p3, 2);
  endtask

  task automatic t_ret();
    run_op(C_RET, 13'h1555, 3'd7, 4'b0, 4'b0);
    chk(pc3 == 13'h0F0F, "R4 pc", pc3, 13'h0F0F);
    chk(fl3 == 3'd7, "R4 flags kept", fl3, 7);
    chk(p3 == 8'h00, "R4 psp-2", p3, 0);
    chk(!g3, "R4 gie unchanged", g3, 0);
  endtask

  task automatic t_wrap();
    mem[8'hFF] = 8'hE3; mem[8'hFE] = 8'h21;
    run_op(C_RETI, 13'h0000, 3'd0, 4'b0, 4'b0);
    chk(a1 == 8'hFF && a2 == 8'hFE, "R9 read wrap", {a1, a2}, 16'hFFFE);
    chk(pc3 == 13'h0321 && fl3 == 3'd7, "R9 restored", {pc3, fl3}, {13'h0321, 3'd7});
    chk(p3 == 8'hFE, "R9 psp wrap down", p3, 8'hFE);
    run_op(C_CALL, 13'h1234, 3'd1, 4'b0, 4'b0);
    chk(p3 == 8'h00, "R9 psp wrap up", p3, 0);
    chk(mem[8'hFE] == 8'h34 && mem[8'hFF] == 8'h32, "R9 write wrap",
        {mem[8'hFE], mem[8'hFF]}, 16'h3432);
  endtask

  task automatic t_busy_ignore();
    // gie is 1 here; an int taken while busy would clear it
    run_op(C_CALL, 13'h0111, 3'd0, C_RET, C_INT);
    chk(p3 == 8'h02, "R8 psp after op", p3, 2);
    chk(!b4, "R8 no extra op", b4, 0);
    chk(gie, "R8 gie kept", gie, 1);
    @(negedge clk);
    chk(psp == 8'h02 && !busy, "R8 still idle", {psp, busy}, {8'h02, 1'b0});
  endtask

  task automatic t_prio();
    run_op(C_INT | C_RET, 13'h0AAA, 3'd3, 4'b0, 4'b0);
    chk(we1 && p3 == 8'h04, "R10 int over ret", {we1, p3}, {1'b1, 8'h04});
    chk(!g1, "R10 int gie", g1, 0);
    run_op(C_CALL | C_RETI, 13'h0BBB, 3'd4, 4'b0, 4'b0);
    chk(we1 && p3 == 8'h06, "R10 call over reti", {we1, p3}, {1'b1, 8'h06});
    run_op(C_RETI | C_RET, 13'h0000, 3'd1, 4'b0, 4'b0);
    chk(pc3 == 13'h0BBB && fl3 == 3'd4 && g3, "R10 reti over ret",
        {pc3, fl3, g3}, {13'h0BBB, 3'd4, 1'b1});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_call();
    t_reti();
    t_int();
    t_ret();
    t_wrap();
    t_busy_ignore();
    t_prio();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule